// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps the processor's privilege level (user or supervisor) and is the only agent allowed to move it. Each cycle the execute stage presents the instruction it holds, together with fault flags from decode, the ALU and the memory bounds checker. The block decides between four outcomes:
- take a synchronous exception;
- take an enabled interrupt;
- perform a privileged return;
- let the instruction complete and apply its status-register or condition-code update.

On a trap it stashes the resume address and the status word, latches a 4-bit cause code and enters supervisor mode. One cycle later it emits a redirect to the handler address held for that cause in a 16-entry vector table. On a privileged return it restores the stashed status word and redirects to the stashed address.

The status word carries the mode bit, four condition codes, a global interrupt enable and one enable per interrupt line. Software can reach the privileged state only through a trap, an interrupt or the supervisor-call gate. Privileged operations attempted from user mode become traps. The block has no streaming interface. Every pin is a plain level or a one-cycle pulse, and nothing stalls: the redirect pulse must be consumed by the fetch stage in the cycle it appears.

Top module: `privtrap_ctrl`

## Requirements
- R1: After reset the mode is supervisor (`mode_sup`=1), the status word is 1 (only bit 0 set), `epc_o`, `esr_o` and `cause_o` read 0, and no pulse output is high. Vector entry k holds VEC_RST_BASE + k*VEC_RST_STRIDE.
- R2: The status word has these fields: bit 0 is mode (1 = supervisor), bits 1..4 are the condition codes zero, positive, negative and overflow, bit 5 is the global interrupt enable, and bits 6.. hold one enable per interrupt line (bit 6+i for line i). A completing instruction with `cc_upd` loads `cc_in` into bits 1..4 one cycle later, in either mode.
- R3: A completing `sr_wr` in supervisor mode replaces the whole status word. In user mode it changes only bits 1..4, so mode, global enable and line enables stay as they were. An `sr_wr` takes precedence over `cc_upd` in the same cycle.
- R4: In user mode, an instruction flagged `ex_priv_op` or `ex_ret` does not execute. It raises a trap with cause 2.
- R5: Trap entry becomes visible one cycle after the instruction. At that point `mode_sup`=1, bit 5 of the status word is 0, and `esr_o` holds the prior status word. `cause_o` holds the cause. `save_pulse` and `redirect_valid` are high, and `redirect_pc` equals the vector entry for the cause. `epc_o` holds `ex_pc`+INSTR_BYTES for a synchronous exception and `ex_pc` for an interrupt. User mode changes to supervisor mode only in such a cycle.
- R6: Synchronous causes are ranked, highest first: illegal opcode (code 1), privilege violation (2), bounds fault (4), permission fault (5), divide by zero (3), gate call (0). Any synchronous cause beats interrupts.
- R7: Interrupt line i is taken with code 8+i only when there is a valid instruction, bit 5 is set, bit 6+i is set and the line is high. The lowest pending index wins. A taken interrupt preempts a non-faulting instruction, including a return.
- R8: A trap taken in supervisor mode vectors and stashes exactly as in R5, and the mode stays supervisor.
- R9: A supervisor `ex_ret` with no other cause restores the status word from `esr_o`, redirects to `epc_o` one cycle later and pulses `restore_pulse`.
- R10: `vec_wr` writes entry `vec_idx` only in supervisor mode. In user mode the table is unchanged.
- R11: Without `ex_valid` no trap, return or status update occurs. Status writes and condition-code updates of an instruction that traps or returns are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | An instruction sits in execute this cycle |
| ex_pc | input | XLEN | Address of that instruction |
| ex_gate | input | 1 | Supervisor-call gate instruction |
| ex_illegal | input | 1 | Undecodable opcode |
| ex_divzero | input | 1 | Division by zero |
| ex_mem_fault | input | 1 | Address outside the thread's bounds |
| ex_perm_fault | input | 1 | Access kind not permitted by the region |
| ex_priv_op | input | 1 | Decode saw a privileged operation |
| ex_ret | input | 1 | Privileged return instruction |
| irq | input | IRQ_N | External interrupt lines |
| sr_wr | input | 1 | Instruction writes the status word |
| sr_wdata | input | 6+IRQ_N | Status word to write |
| cc_upd | input | 1 | ALU updates condition codes |
| cc_in | input | 4 | New condition codes {V,N,P,Z} |
| vec_wr | input | 1 | Vector table write strobe |
| vec_idx | input | CAUSE_W | Vector entry to write |
| vec_wdata | input | XLEN | Handler address to write |
| mode_sup | output | 1 | 1 = supervisor, 0 = user |
| status_o | output | 6+IRQ_N | Current status word |
| epc_o | output | XLEN | Stashed resume address |
| esr_o | output | 6+IRQ_N | Stashed status word |
| cause_o | output | CAUSE_W | Latched cause code |
| redirect_valid | output | 1 | Fetch must jump to `redirect_pc` |
| redirect_pc | output | XLEN | Handler or resume address |
| save_pulse | output | 1 | Trap entry stashed PC and status |
| restore_pulse | output | 1 | Return restored PC and status |

## Verification
The bench builds the block with three interrupt lines, a reset vector base of 0x4000 and an entry stride of 0x40. With these settings, codes 0–5 and 8–10 are reachable, and every overlap of fault flags, line enables and the global enable is hit many times within a few thousand cycles. Random supervisor status writes clear the mode bit, which lets the stimulus alternate between user and supervisor mode. This exercises privilege-violation traps, user-side write filtering and nested supervisor traps. The distinct per-entry reset values make a wrong vector index or a dropped table write visible on `redirect_pc`.

// File: rtl/privtrap_pkg.sv
package privtrap_pkg;

  // status word field positions (decoded by neighbours)
  localparam int SR_MODE   = 0;
  localparam int SR_CC_LO  = 1;
  localparam int CC_W      = 4;
  localparam int SR_GIE    = 5;
  localparam int SR_IEN_LO = 6;

  // synchronous cause codes
  localparam int CZ_GATE    = 0;
  localparam int CZ_ILLEGAL = 1;
  localparam int CZ_PRIV    = 2;
  localparam int CZ_DIVZ    = 3;
  localparam int CZ_MEMF    = 4;
  localparam int CZ_PERM    = 5;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SYNC = 2'd1,
    EV_IRQ  = 2'd2,
    EV_RET  = 2'd3
  } trap_ev_e;

  typedef struct packed {
    logic illegal;
    logic priv_op;
    logic mem_fault;
    logic perm_fault;
    logic divzero;
    logic gate;
  } sync_req_t;

endpackage

// File: rtl/privtrap_arbiter.sv
module privtrap_arbiter
  import privtrap_pkg::*;
#(
  parameter int IRQ_N   = 4,
  parameter int CAUSE_W = 4
) (
  input  logic                 valid,
  input  logic                 user_mode,
  input  sync_req_t            req,
  input  logic                 ret_req,
  input  logic [IRQ_N-1:0]     irq_pend,
  output trap_ev_e             ev,
  output logic [CAUSE_W-1:0]   code
);

  localparam int IRQ_BASE = 1 << (CAUSE_W - 1);

  logic               priv_hit;
  logic               irq_hit;
  logic [CAUSE_W-1:0] irq_code;

  assign priv_hit = user_mode && (req.priv_op || ret_req);

  always_comb begin
    irq_hit  = 1'b0;
    irq_code = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (irq_pend[i]) begin
        irq_hit  = 1'b1;
        irq_code = CAUSE_W'(IRQ_BASE + i);
      end
    end
  end

  always_comb begin
    ev   = EV_NONE;
    code = '0;
    if (valid) begin
      if (req.illegal) begin
        ev = EV_SYNC; code = CAUSE_W'(CZ_ILLEGAL);
      end else if (priv_hit) begin
        ev = EV_SYNC; code = CAUSE_W'(CZ_PRIV);
      end else if (req.mem_fault) begin
        ev = EV_SYNC; code = CAUSE_W'(CZ_MEMF);
      end else if (req.perm_fault) begin
        ev = EV_SYNC; code = CAUSE_W'(CZ_PERM);
      end else if (req.divzero) begin
        ev = EV_SYNC; code = CAUSE_W'(CZ_DIVZ);
      end else if (req.gate) begin
        ev = EV_SYNC; code = CAUSE_W'(CZ_GATE);
      end else if (irq_hit) begin
        ev = EV_IRQ;  code = irq_code;
      end else if (ret_req) begin
        ev = EV_RET;
      end
    end
  end

endmodule

// File: rtl/privtrap_vectab.sv
module privtrap_vectab #(
  parameter int          XLEN       = 32,
  parameter int          CAUSE_W    = 4,
  parameter logic [31:0] RST_BASE   = 32'h0000_0100,
  parameter logic [31:0] RST_STRIDE = 32'h0000_0010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CAUSE_W-1:0] wr_idx,
  input  logic [XLEN-1:0]    wr_data,
  input  logic [CAUSE_W-1:0] rd_idx,
  output logic [XLEN-1:0]    rd_data
);

  localparam int DEPTH = 1 << CAUSE_W;

  logic [XLEN-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [XLEN-1:0] INIT = XLEN'(RST_BASE + RST_STRIDE * g);
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry[g] <= INIT;
      else if (wr_en && (wr_idx == CAUSE_W'(g)))
        entry[g] <= wr_data;
    end
  end

  assign rd_data = entry[rd_idx];

endmodule

// File: rtl/privtrap_state.sv
module privtrap_state
  import privtrap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IRQ_N   = 4,
  parameter int CAUSE_W = 4,
  localparam int SW     = SR_IEN_LO + IRQ_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trap_ev_e           ev,
  input  logic [CAUSE_W-1:0] code,
  input  logic [XLEN-1:0]    resume_addr,
  input  logic               commit,
  input  logic               sr_wr,
  input  logic [SW-1:0]      sr_wdata,
  input  logic               cc_upd,
  input  logic [CC_W-1:0]    cc_in,
  output logic [SW-1:0]      status,
  output logic [XLEN-1:0]    epc,
  output logic [SW-1:0]      esr,
  output logic [CAUSE_W-1:0] cause
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= SW'(1);
      epc    <= '0;
      esr    <= '0;
      cause  <= '0;
    end else begin
      unique case (ev)
        EV_SYNC, EV_IRQ: begin
          epc             <= resume_addr;
          esr             <= status;
          cause           <= code;
          status[SR_MODE] <= 1'b1;
          status[SR_GIE]  <= 1'b0;
        end
        EV_RET: begin
          status <= esr;
        end
        default: begin
          if (commit) begin
            if (sr_wr) begin
              if (status[SR_MODE])
                status <= sr_wdata;
              else
                status[SR_CC_LO +: CC_W] <= sr_wdata[SR_CC_LO +: CC_W];
            end else if (cc_upd) begin
              status[SR_CC_LO +: CC_W] <= cc_in;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/privtrap_ctrl.sv
module privtrap_ctrl
  import privtrap_pkg::*;
#(
  parameter int          XLEN           = 32,
  parameter int          IRQ_N          = 4,
  parameter int          CAUSE_W        = 4,
  parameter int          INSTR_BYTES    = 4,
  parameter logic [31:0] VEC_RST_BASE   = 32'h0000_0100,
  parameter logic [31:0] VEC_RST_STRIDE = 32'h0000_0010
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ex_valid,
  input  logic [XLEN-1:0]             ex_pc,
  input  logic                        ex_gate,
  input  logic                        ex_illegal,
  input  logic                        ex_divzero,
  input  logic                        ex_mem_fault,
  input  logic                        ex_perm_fault,
  input  logic                        ex_priv_op,
  input  logic                        ex_ret,
  input  logic [IRQ_N-1:0]            irq,
  input  logic                        sr_wr,
  input  logic [SR_IEN_LO+IRQ_N-1:0]  sr_wdata,
  input  logic                        cc_upd,
  input  logic [CC_W-1:0]             cc_in,
  input  logic                        vec_wr,
  input  logic [CAUSE_W-1:0]          vec_idx,
  input  logic [XLEN-1:0]             vec_wdata,
  output logic                        mode_sup,
  output logic [SR_IEN_LO+IRQ_N-1:0]  status_o,
  output logic [XLEN-1:0]             epc_o,
  output logic [SR_IEN_LO+IRQ_N-1:0]  esr_o,
  output logic [CAUSE_W-1:0]          cause_o,
  output logic                        redirect_valid,
  output logic [XLEN-1:0]             redirect_pc,
  output logic                        save_pulse,
  output logic                        restore_pulse
);

  localparam int SW = SR_IEN_LO + IRQ_N;

  sync_req_t          req;
  trap_ev_e           ev;
  logic [CAUSE_W-1:0] code;
  logic [IRQ_N-1:0]   irq_pend;
  logic [XLEN-1:0]    resume_addr;
  logic [XLEN-1:0]    vec_rd;
  logic               commit;

  assign req = '{illegal:    ex_illegal,
                 priv_op:    ex_priv_op,
                 mem_fault:  ex_mem_fault,
                 perm_fault: ex_perm_fault,
                 divzero:    ex_divzero,
                 gate:       ex_gate};

  assign irq_pend    = irq & status_o[SR_IEN_LO +: IRQ_N] & {IRQ_N{status_o[SR_GIE]}};
  assign resume_addr = (ev == EV_IRQ) ? ex_pc : ex_pc + XLEN'(INSTR_BYTES);
  assign commit      = ex_valid && (ev == EV_NONE);
  assign mode_sup    = status_o[SR_MODE];

  privtrap_arbiter #(
    .IRQ_N   (IRQ_N),
    .CAUSE_W (CAUSE_W)
  ) u_arb (
    .valid     (ex_valid),
    .user_mode (!status_o[SR_MODE]),
    .req       (req),
    .ret_req   (ex_ret),
    .irq_pend  (irq_pend),
    .ev        (ev),
    .code      (code)
  );

  privtrap_vectab #(
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W),
    .RST_BASE   (VEC_RST_BASE),
    .RST_STRIDE (VEC_RST_STRIDE)
  ) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (vec_wr && status_o[SR_MODE]),
    .wr_idx  (vec_idx),
    .wr_data (vec_wdata),
    .rd_idx  (code),
    .rd_data (vec_rd)
  );

  privtrap_state #(
    .XLEN    (XLEN),
    .IRQ_N   (IRQ_N),
    .CAUSE_W (CAUSE_W)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev),
    .code        (code),
    .resume_addr (resume_addr),
    .commit      (commit),
    .sr_wr       (sr_wr),
    .sr_wdata    (sr_wdata),
    .cc_upd      (cc_upd),
    .cc_in       (cc_in),
    .status      (status_o),
    .epc         (epc_o),
    .esr         (esr_o),
    .cause       (cause_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      save_pulse     <= 1'b0;
      restore_pulse  <= 1'b0;
    end else begin
      save_pulse     <= (ev == EV_SYNC) || (ev == EV_IRQ);
      restore_pulse  <= (ev == EV_RET);
      redirect_valid <= (ev != EV_NONE);
      if (ev == EV_RET)
        redirect_pc <= epc_o;
      else if (ev != EV_NONE)
        redirect_pc <= vec_rd;
    end
  end

  logic unused_sw;
  assign unused_sw = ^SW;

endmodule

// File: rtl/privtrap_chk.sv
module privtrap_chk
  import privtrap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IRQ_N = 4,
  localparam int SW   = SR_IEN_LO + IRQ_N
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_sup,
  input logic [SW-1:0]   status_o,
  input logic [SW-1:0]   esr_o,
  input logic [XLEN-1:0] epc_o,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            save_pulse,
  input logic            restore_pulse
);

  // R5
  user_exit_only_by_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sup && !$past(mode_sup)) |-> save_pulse);

  // R5
  entry_masks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse |-> (mode_sup && !status_o[SR_GIE]));

  // R5
  entry_stashes_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_pulse |-> (esr_o == $past(status_o)));

  // R5
  redirect_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid == (save_pulse || restore_pulse));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_pulse, restore_pulse}));

  // R9
  return_restores_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_pulse |-> (status_o == $past(esr_o) && redirect_pc == $past(epc_o)));

  // R3
  user_keeps_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mode_sup) && !save_pulse) |->
      (!mode_sup && status_o[SW-1:SR_GIE] == $past(status_o[SW-1:SR_GIE])));

endmodule

bind privtrap_ctrl privtrap_chk #(.XLEN(XLEN), .IRQ_N(IRQ_N)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_sup       (mode_sup),
  .status_o       (status_o),
  .esr_o          (esr_o),
  .epc_o          (epc_o),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .save_pulse     (save_pulse),
  .restore_pulse  (restore_pulse)
);

// File: tb/privtrap_ctrl_bench.sv
`timescale 1ns/1ps
module privtrap_ctrl_bench;

  localparam int          XLEN = 32;
  localparam int          IRQN = 3;
  localparam int          CW   = 4;
  localparam int          IB   = 4;
  localparam logic [31:0] VB   = 32'h0000_4000;
  localparam logic [31:0] VS   = 32'h0000_0040;
  localparam int          SW   = 6 + IRQN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_valid = 0, ex_gate = 0, ex_illegal = 0, ex_divzero = 0;
  logic ex_mem_fault = 0, ex_perm_fault = 0, ex_priv_op = 0, ex_ret = 0;
  logic [XLEN-1:0] ex_pc = '0;
  logic [IRQN-1:0] irq = '0;
  logic            sr_wr = 0, cc_upd = 0, vec_wr = 0;
  logic [SW-1:0]   sr_wdata = '0;
  logic [3:0]      cc_in = '0;
  logic [CW-1:0]   vec_idx = '0;
  logic [XLEN-1:0] vec_wdata = '0;

  logic            mode_sup, redirect_valid, save_pulse, restore_pulse;
  logic [SW-1:0]   status_o, esr_o;
  logic [XLEN-1:0] epc_o, redirect_pc;
  logic [CW-1:0]   cause_o;

  always #2.5 clk = ~clk;

  privtrap_ctrl #(
    .XLEN(XLEN), .IRQ_N(IRQN), .CAUSE_W(CW), .INSTR_BYTES(IB),
    .VEC_RST_BASE(VB), .VEC_RST_STRIDE(VS)
  ) u_privtrap_ctrl (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_pc(ex_pc),
    .ex_gate(ex_gate), .ex_illegal(ex_illegal), .ex_divzero(ex_divzero),
    .ex_mem_fault(ex_mem_fault), .ex_perm_fault(ex_perm_fault),
    .ex_priv_op(ex_priv_op), .ex_ret(ex_ret), .irq(irq),
    .sr_wr(sr_wr), .sr_wdata(sr_wdata), .cc_upd(cc_upd), .cc_in(cc_in),
    .vec_wr(vec_wr), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
    .mode_sup(mode_sup), .status_o(status_o), .epc_o(epc_o), .esr_o(esr_o),
    .cause_o(cause_o), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .save_pulse(save_pulse),
    .restore_pulse(restore_pulse)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  logic [SW-1:0]   m_status, m_esr;
  logic [XLEN-1:0] m_epc, m_rpc;
  logic [CW-1:0]   m_cause;
  logic            m_rv, m_save, m_rest;
  logic [XLEN-1:0] m_vec [16];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] vec_reset(input int k);
    return VB + VS * k;
  endfunction

  task automatic idle();
    ex_valid = 0; ex_gate = 0; ex_illegal = 0; ex_divzero = 0;
    ex_mem_fault = 0; ex_perm_fault = 0; ex_priv_op = 0; ex_ret = 0;
    irq = '0; sr_wr = 0; cc_upd = 0; vec_wr = 0;
  endtask

  // Predict next state from current model state and driven inputs, then compare.
  task automatic step();
    string tag;
    logic user, privhit, take_irq, do_ret, sync;
    logic [IRQN-1:0] pend;
    logic [CW-1:0] code;
    int nsync;
    logic [SW-1:0] n_status;
    user = !m_status[0];
    privhit = user && (ex_priv_op || ex_ret);
    pend = irq & m_status[6 +: IRQN] & {IRQN{m_status[5]}};
    nsync = int'(ex_illegal) + int'(privhit) + int'(ex_mem_fault) + int'(ex_perm_fault)
          + int'(ex_divzero) + int'(ex_gate);
    sync = 0; take_irq = 0; do_ret = 0; code = '0;
    if (ex_valid) begin
      if (ex_illegal)         begin sync = 1; code = 4'd1; end
      else if (privhit)       begin sync = 1; code = 4'd2; end
      else if (ex_mem_fault)  begin sync = 1; code = 4'd4; end
      else if (ex_perm_fault) begin sync = 1; code = 4'd5; end
      else if (ex_divzero)    begin sync = 1; code = 4'd3; end
      else if (ex_gate)       begin sync = 1; code = 4'd0; end
      else if (|pend) begin
        take_irq = 1;
        for (int i = IRQN - 1; i >= 0; i--) if (pend[i]) code = CW'(8 + i);
      end else if (ex_ret) do_ret = 1;
    end
    if (!ex_valid)                     tag = "R11";
    else if (sync && code == 4'd2 && nsync == 1) tag = "R4";
    else if (sync && (nsync > 1 || |pend)) tag = "R6";
    else if (sync && !user)            tag = "R8";
    else if (sync)                     tag = "R5";
    else if (take_irq)                 tag = "R7";
    else if (do_ret)                   tag = "R9";
    else if (vec_wr)                   tag = "R10";
    else if (sr_wr && user)            tag = "R3";
    else                               tag = "R2";

    n_status = m_status;
    m_save = 0; m_rest = 0; m_rv = 0;
    if (sync || take_irq) begin
      m_epc = take_irq ? ex_pc : ex_pc + IB;
      m_esr = m_status;
      m_cause = code;
      n_status[0] = 1'b1;
      n_status[5] = 1'b0;
      m_rv = 1; m_save = 1; m_rpc = m_vec[code];
    end else if (do_ret) begin
      n_status = m_esr;
      m_rv = 1; m_rest = 1; m_rpc = m_epc;
    end else if (ex_valid) begin
      if (sr_wr) begin
        if (!user) n_status = sr_wdata;
        else n_status[4:1] = sr_wdata[4:1];
      end else if (cc_upd) n_status[4:1] = cc_in;
    end
    if (vec_wr && !user) m_vec[vec_idx] = vec_wdata;
    m_status = n_status;

    @(posedge clk); #1;
    chk(tag, "mode", 32'(mode_sup), 32'(m_status[0]));
    chk(tag, "status", 32'(status_o), 32'(m_status));
    chk(tag, "epc", epc_o, m_epc);
    chk(tag, "esr", 32'(esr_o), 32'(m_esr));
    chk(tag, "cause", 32'(cause_o), 32'(m_cause));
    chk(tag, "redirect_valid", 32'(redirect_valid), 32'(m_rv));
    if (m_rv) chk(tag, "redirect_pc", redirect_pc, m_rpc);
    chk(tag, "save", 32'(save_pulse), 32'(m_save));
    chk(tag, "restore", 32'(restore_pulse), 32'(m_rest));
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_0042);
    idle();
    m_status = SW'(1); m_esr = '0; m_epc = '0; m_cause = '0;
    m_rv = 0; m_rpc = '0; m_save = 0; m_rest = 0;
    for (int k = 0; k < 16; k++) m_vec[k] = vec_reset(k);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk("R1", "mode", 32'(mode_sup), 32'd1);
    chk("R1", "status", 32'(status_o), 32'd1);
    chk("R1", "cause", 32'(cause_o), 32'd0);
    chk("R1", "epc", epc_o, 32'd0);
    chk("R1", "pulses", 32'({redirect_valid, save_pulse, restore_pulse}), 32'd0);

    // R1: gate from supervisor reaches reset vector 0
    ex_valid = 1; ex_pc = 32'h100; ex_gate = 1; step(); idle();
    chk("R1", "vector0", redirect_pc, VB);

    // enter user mode with gie and all line enables on (R3 setup)
    ex_valid = 1; sr_wr = 1; sr_wdata = SW'({3'b111, 1'b1, 4'b0000, 1'b0}); step(); idle();
    // R3: user write tries to set mode bit and clear enables
    ex_valid = 1; sr_wr = 1; sr_wdata = SW'({3'b000, 1'b0, 4'b1010, 1'b1}); step(); idle();
    // R10: user vector write is ignored, then R4 trap shows the old vector 2
    vec_wr = 1; vec_idx = 4'd2; vec_wdata = 32'hDEAD_0000; step(); idle();
    ex_valid = 1; ex_pc = 32'h200; ex_priv_op = 1; step(); idle();
    chk("R10", "vector2", redirect_pc, vec_reset(2));
    // R9: return to user
    ex_valid = 1; ex_ret = 1; step(); idle();
    // R6: all faults plus irqs at once
    ex_valid = 1; ex_illegal = 1; ex_divzero = 1; ex_gate = 1; ex_mem_fault = 1; irq = '1; step(); idle();
    ex_valid = 1; ex_ret = 1; step(); idle();
    // R7: two lines pending in user mode, lowest wins
    ex_valid = 1; ex_pc = 32'h300; irq = 3'b110; step(); idle();
    // R11: flags without a valid instruction
    ex_gate = 1; ex_illegal = 1; sr_wr = 1; sr_wdata = '0; step(); idle();

    for (int n = 0; n < 6000; n++) begin
      ex_valid      = ($urandom % 10) < 8;
      ex_pc         = $urandom & 32'hFFFF_FFFC;
      ex_gate       = ($urandom % 14) == 0;
      ex_illegal    = ($urandom % 20) == 0;
      ex_divzero    = ($urandom % 20) == 0;
      ex_mem_fault  = ($urandom % 20) == 0;
      ex_perm_fault = ($urandom % 20) == 0;
      ex_priv_op    = ($urandom % 12) == 0;
      ex_ret        = ($urandom % 8) == 0;
      irq           = IRQN'($urandom);
      sr_wr         = ($urandom % 7) == 0;
      sr_wdata      = SW'($urandom);
      cc_upd        = ($urandom % 3) == 0;
      cc_in         = 4'($urandom);
      vec_wr        = ($urandom % 10) == 0;
      vec_idx       = CW'($urandom);
      vec_wdata     = $urandom & 32'hFFFF_FFFC;
      step();
    end
    idle();
    summary();
    $finish;
  end

endmodule